// File: doc/BRIEF.md
# Scoreboard Hazard Issue Controller

This block is the central hazard bookkeeper for a small set of functional units that share one register file and do no register renaming. It takes one decoded instruction at a time: the unit class it needs, one destination register and two source registers. It decides whether that instruction may enter a unit. For every unit in flight it then decides when the operands may be read and when the result may be written back. Each unit reports the end of its execution with a one-cycle completion pulse. The block does no arithmetic and holds no register values. It only issues permissions.

Every hazard is resolved by waiting. Issue waits while the requested unit is occupied, or while any instruction in flight still has to write the same destination. Operand reads wait until neither source has a pending producer. A finished result waits while an instruction that was issued earlier has not yet read the old contents of that register. Units can finish out of order. When several units could write back in the same cycle, one is chosen by fixed priority.

The producer holds an instruction on the input until it sees the acknowledge pulse. All three outputs are registered, single-cycle pulses.

Top module: `scoreboard_ctl`

## Requirements
- R1: While reset is high, and in the first cycle after it, issue_ack, rd_grant and wb_grant are all zero, and every unit and register is free.
- R2: A held instruction of class c (0 to NUM_FU-1, naming unit c) is accepted at a clock edge when unit c is free and its destination has no pending writer. issue_ack is high for exactly the following cycle.
- R3: An instruction whose unit is occupied is not accepted. A second instruction to the same unit is acknowledged exactly one cycle after the first one's wb_grant pulse.
- R4: An instruction whose destination is still to be written by an earlier instruction in flight (WAW) is acknowledged exactly one cycle after that writer's wb_grant pulse.
- R5: rd_grant[u] pulses once per instruction in unit u, after its issue_ack, and only when neither source has a pending producer. With no pending producer it comes exactly one cycle after issue_ack.
- R6: A source with a pending producer becomes readable through that producer's writeback. The consumer's rd_grant comes exactly one cycle after the producer's wb_grant.
- R7: A finished unit is not granted writeback while some issued, not-yet-read instruction names its destination as a source that is not waiting on a producer (WAR). The grant follows exactly one cycle after that instruction's rd_grant.
- R8: At most one wb_grant bit is high per cycle. If several units are eligible, the lowest-numbered unit wins and the next one follows in the next cycle.
- R9: fu_done[u] has effect only while unit u is executing, meaning after its rd_grant and before writeback. Without contention, wb_grant[u] comes exactly LAT+2 cycles after rd_grant[u], where LAT is the number of cycles from the read grant to the done pulse. A done pulse to an idle unit produces no wb_grant.
- R10: An instruction accepted at the same edge at which its source's producer is granted writeback treats that source as available. Its rd_grant comes one cycle after issue_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented; held until issue_ack |
| in_fu | input | FU_W | Unit class requested (index of the unit) |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| fu_done | input | NUM_FU | One-cycle completion pulse per unit |
| issue_ack | output | 1 | Pulse: presented instruction was accepted |
| rd_grant | output | NUM_FU | Pulse per unit: operands may be read now |
| wb_grant | output | NUM_FU | Pulse per unit (one-hot or zero): result may be written |

## Verification
A wrong unit-status entry or register-owner entry surfaces at the ports as a grant that fires early or never fires. A lost owner lets a WAW instruction be acknowledged before the earlier writer's wb_grant. A stale availability flag moves rd_grant off its one-cycle relation to the producer's wb_grant. A wrong WAR scan moves wb_grant relative to the reader's rd_grant. Because every output is a registered pulse with fixed cycle relations, a reference model compared on every clock flags such a divergence within one or two cycles of the edge where the state went wrong. Directed timing checks pin each hazard relation to an exact cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_EXEC = 2'd2,
    PH_DONE = 2'd3
  } fu_phase_t;
endpackage

// File: rtl/sb_reg_table.sv
module sb_reg_table #(
  parameter int NUM_REG = 16,
  parameter int FU_W    = 2,
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [FU_W-1:0]  set_unit,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  input  logic [REG_W-1:0] rd_dst,
  input  logic [REG_W-1:0] rd_s1,
  input  logic [REG_W-1:0] rd_s2,
  output logic             dst_pend,
  output logic             s1_pend,
  output logic [FU_W-1:0]  s1_unit,
  output logic             s2_pend,
  output logic [FU_W-1:0]  s2_unit
);
  logic [NUM_REG-1:0] pend;
  logic [FU_W-1:0]    owner [NUM_REG];

  // pending flags need reset; owner field is plain storage
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      if (clr_en) pend[clr_reg] <= 1'b0;
      if (set_en) pend[set_reg] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) owner[set_reg] <= set_unit;
  end

  assign dst_pend = pend[rd_dst];
  assign s1_pend  = pend[rd_s1];
  assign s1_unit  = owner[rd_s1];
  assign s2_pend  = pend[rd_s2];
  assign s2_unit  = owner[rd_s2];
endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int FU_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_en,
  input  logic [REG_W-1:0] set_dst,
  input  logic [REG_W-1:0] set_src1,
  input  logic [REG_W-1:0] set_src2,
  input  logic             set_q1_v,
  input  logic [FU_W-1:0]  set_q1,
  input  logic             set_q2_v,
  input  logic [FU_W-1:0]  set_q2,
  input  logic             rd_go,
  input  logic             done_in,
  input  logic             wb_go,
  input  logic             wb_any,
  input  logic [FU_W-1:0]  wb_idx,
  output logic             busy,
  output logic             waiting,
  output logic             finished,
  output logic [REG_W-1:0] dst,
  output logic [REG_W-1:0] src1,
  output logic [REG_W-1:0] src2,
  output logic             src1_ok,
  output logic             src2_ok
);
  fu_phase_t       phase;
  logic            q1_v, q2_v;
  logic [FU_W-1:0] q1, q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      q1_v    <= 1'b0;
      q2_v    <= 1'b0;
      src1_ok <= 1'b0;
      src2_ok <= 1'b0;
    end else if (issue_en) begin
      phase   <= PH_WAIT;
      dst     <= set_dst;
      src1    <= set_src1;
      src2    <= set_src2;
      q1_v    <= set_q1_v;
      q1      <= set_q1;
      q2_v    <= set_q2_v;
      q2      <= set_q2;
      src1_ok <= !set_q1_v;
      src2_ok <= !set_q2_v;
    end else begin
      // a producer broadcasting its writeback releases our wait on it
      if (wb_any && q1_v && q1 == wb_idx) begin
        q1_v    <= 1'b0;
        src1_ok <= 1'b1;
      end
      if (wb_any && q2_v && q2 == wb_idx) begin
        q2_v    <= 1'b0;
        src2_ok <= 1'b1;
      end
      if (rd_go) begin
        phase   <= PH_EXEC;
        src1_ok <= 1'b0;
        src2_ok <= 1'b0;
      end
      if (done_in && phase == PH_EXEC) phase <= PH_DONE;
      if (wb_go) phase <= PH_IDLE;
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign waiting  = (phase == PH_WAIT);
  assign finished = (phase == PH_DONE);
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int NUM_FU = 4,
  parameter int REG_W  = 4,
  localparam int FU_W  = $clog2(NUM_FU)
) (
  input  logic [NUM_FU-1:0]       done_v,
  input  logic [NUM_FU-1:0]       wait_v,
  input  logic [NUM_FU-1:0]       ok1_v,
  input  logic [NUM_FU-1:0]       ok2_v,
  input  logic [NUM_FU*REG_W-1:0] dst_flat,
  input  logic [NUM_FU*REG_W-1:0] s1_flat,
  input  logic [NUM_FU*REG_W-1:0] s2_flat,
  output logic [NUM_FU-1:0]       grant,
  output logic                    any,
  output logic [FU_W-1:0]         idx,
  output logic [REG_W-1:0]        wreg
);
  logic [REG_W-1:0]  dst_a [NUM_FU];
  logic [REG_W-1:0]  s1_a  [NUM_FU];
  logic [REG_W-1:0]  s2_a  [NUM_FU];
  logic [NUM_FU-1:0] blocked;
  logic [NUM_FU-1:0] eligible;

  for (genvar g = 0; g < NUM_FU; g++) begin : g_unpack
    assign dst_a[g] = dst_flat[g*REG_W +: REG_W];
    assign s1_a[g]  = s1_flat[g*REG_W +: REG_W];
    assign s2_a[g]  = s2_flat[g*REG_W +: REG_W];
  end

  // WAR scan: any unread, available source equal to our destination blocks us
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      blocked[u] = 1'b0;
      for (int f = 0; f < NUM_FU; f++) begin
        if (wait_v[f] && ((ok1_v[f] && s1_a[f] == dst_a[u]) ||
                          (ok2_v[f] && s2_a[f] == dst_a[u])))
          blocked[u] = 1'b1;
      end
    end
  end

  assign eligible = done_v & ~blocked;

  // fixed priority, lowest index wins
  always_comb begin
    grant = '0;
    any   = 1'b0;
    idx   = '0;
    wreg  = '0;
    for (int u = NUM_FU - 1; u >= 0; u--) begin
      if (eligible[u]) begin
        grant    = '0;
        grant[u] = 1'b1;
        any      = 1'b1;
        idx      = FU_W'(u);
        wreg     = dst_a[u];
      end
    end
  end
endmodule

// File: rtl/scoreboard_ctl.sv
module scoreboard_ctl #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 16,
  localparam int FU_W   = $clog2(NUM_FU),
  localparam int REG_W  = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FU_W-1:0]   in_fu,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src1,
  input  logic [REG_W-1:0]  in_src2,
  input  logic [NUM_FU-1:0] fu_done,
  output logic              issue_ack,
  output logic [NUM_FU-1:0] rd_grant,
  output logic [NUM_FU-1:0] wb_grant
);
  logic [NUM_FU-1:0]       busy_v, wait_v, done_v, ok1_v, ok2_v;
  logic [NUM_FU*REG_W-1:0] dst_flat, s1_flat, s2_flat;
  logic                    dst_pend, s1_pend, s2_pend;
  logic [FU_W-1:0]         s1_unit, s2_unit;
  logic [NUM_FU-1:0]       wb_go, rd_go;
  logic                    wb_any;
  logic [FU_W-1:0]         wb_idx;
  logic [REG_W-1:0]        wb_reg;
  logic                    class_ok, issue_go, q1_v, q2_v;

  sb_reg_table #(.NUM_REG(NUM_REG), .FU_W(FU_W)) u_regs (
    .clk(clk), .rst(rst),
    .set_en(issue_go), .set_reg(in_dst), .set_unit(in_fu),
    .clr_en(wb_any), .clr_reg(wb_reg),
    .rd_dst(in_dst), .rd_s1(in_src1), .rd_s2(in_src2),
    .dst_pend(dst_pend), .s1_pend(s1_pend), .s1_unit(s1_unit),
    .s2_pend(s2_pend), .s2_unit(s2_unit)
  );

  assign class_ok = (in_fu <= FU_W'(NUM_FU - 1));
  // structural and WAW stall, both against the state before this edge
  assign issue_go = in_valid && class_ok && !busy_v[in_fu] && !dst_pend;
  // a producer writing back at this very edge counts as already delivered
  assign q1_v = s1_pend && !(wb_any && s1_unit == wb_idx);
  assign q2_v = s2_pend && !(wb_any && s2_unit == wb_idx);
  assign rd_go = wait_v & ok1_v & ok2_v;

  for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
    sb_fu_entry #(.REG_W(REG_W), .FU_W(FU_W)) u_entry (
      .clk(clk), .rst(rst),
      .issue_en(issue_go && in_fu == FU_W'(g)),
      .set_dst(in_dst), .set_src1(in_src1), .set_src2(in_src2),
      .set_q1_v(q1_v), .set_q1(s1_unit), .set_q2_v(q2_v), .set_q2(s2_unit),
      .rd_go(rd_go[g]), .done_in(fu_done[g]), .wb_go(wb_go[g]),
      .wb_any(wb_any), .wb_idx(wb_idx),
      .busy(busy_v[g]), .waiting(wait_v[g]), .finished(done_v[g]),
      .dst(dst_flat[g*REG_W +: REG_W]),
      .src1(s1_flat[g*REG_W +: REG_W]),
      .src2(s2_flat[g*REG_W +: REG_W]),
      .src1_ok(ok1_v[g]), .src2_ok(ok2_v[g])
    );
  end

  sb_wb_arb #(.NUM_FU(NUM_FU), .REG_W(REG_W)) u_arb (
    .done_v(done_v), .wait_v(wait_v), .ok1_v(ok1_v), .ok2_v(ok2_v),
    .dst_flat(dst_flat), .s1_flat(s1_flat), .s2_flat(s2_flat),
    .grant(wb_go), .any(wb_any), .idx(wb_idx), .wreg(wb_reg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_ack <= 1'b0;
      rd_grant  <= '0;
      wb_grant  <= '0;
    end else begin
      issue_ack <= issue_go;
      rd_grant  <= rd_go;
      wb_grant  <= wb_go;
    end
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_FU = 4,
  parameter int FU_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [FU_W-1:0]   in_fu,
  input logic              issue_ack,
  input logic [NUM_FU-1:0] rd_grant,
  input logic [NUM_FU-1:0] wb_grant
);
  logic [FU_W-1:0]   cls_q;
  logic [NUM_FU-1:0] occ, read_done;

  always_ff @(posedge clk) begin
    cls_q <= in_fu;
    if (rst) begin
      occ       <= '0;
      read_done <= '0;
    end else begin
      for (int u = 0; u < NUM_FU; u++) begin
        if (wb_grant[u]) begin
          occ[u]       <= 1'b0;
          read_done[u] <= 1'b0;
        end
        if (issue_ack && cls_q == FU_W'(u)) occ[u] <= 1'b1;
        if (rd_grant[u]) read_done[u] <= 1'b1;
      end
    end
  end

  assert_wb_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wb_grant));

  assert_ack_needs_request_R2: assert property (@(posedge clk) disable iff (rst)
    issue_ack |-> $past(in_valid));

  for (genvar g = 0; g < NUM_FU; g++) begin : g_chk
    assert_no_double_issue_R3: assert property (@(posedge clk) disable iff (rst)
      (issue_ack && cls_q == FU_W'(g)) |-> !occ[g]);

    assert_read_once_after_issue_R5: assert property (@(posedge clk) disable iff (rst)
      rd_grant[g] |-> (occ[g] && !read_done[g]));

    assert_wb_after_read_R9: assert property (@(posedge clk) disable iff (rst)
      wb_grant[g] |-> read_done[g]);
  end
endmodule

bind scoreboard_ctl sb_checker #(.NUM_FU(NUM_FU), .FU_W(FU_W)) u_sb_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_fu(in_fu),
  .issue_ack(issue_ack), .rd_grant(rd_grant), .wb_grant(wb_grant)
);

// File: tb/scoreboard_ctl_bench.sv
module scoreboard_ctl_bench;
  localparam int NF = 4;
  localparam int NR = 16;
  localparam int FW = 2;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          in_valid = 1'b0;
  logic [FW-1:0] in_fu = '0;
  logic [RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [NF-1:0] fu_done = '0;
  logic          issue_ack;
  logic [NF-1:0] rd_grant, wb_grant;

  scoreboard_ctl #(.NUM_FU(NF), .NUM_REG(NR)) u_scoreboard_ctl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fu(in_fu),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .fu_done(fu_done), .issue_ack(issue_ack),
    .rd_grant(rd_grant), .wb_grant(wb_grant)
  );

  int lat [NF] = '{2, 2, 6, 3};
  int checks = 0, fails = 0, cyc = 0;
  int rd_cyc [NF], wb_cyc [NF], wb_cnt [NF], cnt [NF];
  bit [NF-1:0] auto_en = '1;
  bit [NF-1:0] man_mask = '0;
  int man_seq = 0, man_seen = 0;

  // ---------------- behavioural reference model ----------------
  // phase: 0 free, 1 waiting operands, 2 executing, 3 finished
  int m_ph [NF], m_fi [NF], m_fj [NF], m_fk [NF], m_qj [NF], m_qk [NF];
  bit m_rj [NF], m_rk [NF];
  int m_reg [NR];
  bit e_ack = 0;
  bit [NF-1:0] e_rd = '0, e_wb = '0;

  task automatic model_step();
    int win, p1, p2;
    bit blk, acc;
    bit [NF-1:0] rdv;
    if (rst) begin
      foreach (m_ph[u]) begin
        m_ph[u] = 0; m_qj[u] = -1; m_qk[u] = -1; m_rj[u] = 0; m_rk[u] = 0;
      end
      foreach (m_reg[r]) m_reg[r] = -1;
      e_ack = 0; e_rd = '0; e_wb = '0;
      return;
    end
    win = -1;
    for (int u = 0; u < NF; u++) begin
      if (win < 0 && m_ph[u] == 3) begin
        blk = 0;
        for (int f = 0; f < NF; f++)
          if (m_ph[f] == 1 && ((m_rj[f] && m_fj[f] == m_fi[u]) ||
                               (m_rk[f] && m_fk[f] == m_fi[u]))) blk = 1;
        if (!blk) win = u;
      end
    end
    for (int u = 0; u < NF; u++) rdv[u] = (m_ph[u] == 1) && m_rj[u] && m_rk[u];
    acc = in_valid && m_ph[in_fu] == 0 && m_reg[in_dst] < 0;
    p1 = m_reg[in_src1];
    p2 = m_reg[in_src2];
    if (win >= 0 && p1 == win) p1 = -1;
    if (win >= 0 && p2 == win) p2 = -1;
    if (win >= 0) begin
      for (int f = 0; f < NF; f++) begin
        if (m_qj[f] == win) begin m_qj[f] = -1; m_rj[f] = 1; end
        if (m_qk[f] == win) begin m_qk[f] = -1; m_rk[f] = 1; end
      end
      m_reg[m_fi[win]] = -1;
      m_ph[win] = 0;
    end
    for (int u = 0; u < NF; u++) if (fu_done[u] && m_ph[u] == 2) m_ph[u] = 3;
    for (int u = 0; u < NF; u++)
      if (rdv[u]) begin m_ph[u] = 2; m_rj[u] = 0; m_rk[u] = 0; end
    if (acc) begin
      m_ph[in_fu] = 1;
      m_fi[in_fu] = int'(in_dst); m_fj[in_fu] = int'(in_src1); m_fk[in_fu] = int'(in_src2);
      m_qj[in_fu] = p1; m_qk[in_fu] = p2;
      m_rj[in_fu] = (p1 < 0); m_rk[in_fu] = (p2 < 0);
      m_reg[in_dst] = int'(in_fu);
    end
    e_ack = acc;
    e_rd  = rdv;
    e_wb  = '0;
    if (win >= 0) e_wb[win] = 1'b1;
  endtask

  always @(posedge clk) model_step();

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // ---------------- monitor: compare, record, completion pulses ----------------
  always @(negedge clk) begin
    cyc++;
    check(issue_ack === e_ack, "R2 issue_ack vs model", int'(issue_ack), int'(e_ack));
    check(rd_grant === e_rd, "R5 rd_grant vs model", int'(rd_grant), int'(e_rd));
    check(wb_grant === e_wb, "R8 wb_grant vs model", int'(wb_grant), int'(e_wb));
    for (int u = 0; u < NF; u++) begin
      if (rd_grant[u] === 1'b1) rd_cyc[u] = cyc;
      if (wb_grant[u] === 1'b1) begin wb_cyc[u] = cyc; wb_cnt[u]++; end
    end
    fu_done = '0;
    for (int u = 0; u < NF; u++) begin
      if (cnt[u] > 0) begin
        cnt[u]--;
        if (cnt[u] == 0) begin fu_done[u] = 1'b1; cnt[u] = -1; end
      end
      if (rd_grant[u] === 1'b1 && auto_en[u]) cnt[u] = lat[u];
    end
    if (man_seq != man_seen) begin
      fu_done  = fu_done | man_mask;
      man_seen = man_seq;
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  // ---------------- driver tasks ----------------
  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic issue(int u, int d, int a, int b, output int ack_at);
    @(negedge clk);
    #1;
    in_valid = 1'b1;
    in_fu = FW'(u); in_dst = RW'(d); in_src1 = RW'(a); in_src2 = RW'(b);
    do begin
      @(negedge clk);
      #1;
    end while (issue_ack !== 1'b1);
    ack_at = cyc;
    in_valid = 1'b0;
  endtask

  task automatic fire(bit [NF-1:0] mask);
    man_mask = mask;
    man_seq++;
  endtask

  initial begin
    int a0, a1, a2, n3;
    foreach (cnt[u]) begin cnt[u] = -1; rd_cyc[u] = 0; wb_cyc[u] = 0; wb_cnt[u] = 0; end

    // R1: reset state
    wait_cyc(3);
    check(issue_ack === 1'b0 && rd_grant === '0 && wb_grant === '0,
          "R1 outputs during reset", int'({issue_ack, rd_grant, wb_grant}), 0);
    rst = 1'b0;
    wait_cyc(1);
    check(issue_ack === 1'b0 && rd_grant === '0 && wb_grant === '0,
          "R1 outputs after reset", int'({issue_ack, rd_grant, wb_grant}), 0);

    // R2, R5, R9: lone instruction, no hazards
    issue(0, 1, 2, 3, a0);
    wait_cyc(10);
    check(rd_cyc[0] == a0 + 1, "R5 read grant one cycle after ack", rd_cyc[0], a0 + 1);
    check(wb_cyc[0] == rd_cyc[0] + lat[0] + 2, "R9 writeback after latency",
          wb_cyc[0], rd_cyc[0] + lat[0] + 2);

    // R3: structural stall on the same unit
    issue(1, 4, 2, 3, a0);
    issue(1, 6, 2, 3, a1);
    check(a1 == wb_cyc[1] + 1, "R3 second issue follows writeback", a1, wb_cyc[1] + 1);
    wait_cyc(20);

    // R4: WAW stall on a different unit
    issue(2, 5, 2, 3, a0);
    issue(0, 5, 2, 3, a1);
    check(a1 == wb_cyc[2] + 1, "R4 WAW issue follows writer", a1, wb_cyc[2] + 1);
    wait_cyc(20);

    // R6: RAW wait for producer writeback
    issue(2, 7, 2, 3, a0);
    issue(0, 8, 7, 1, a1);
    wait_cyc(20);
    check(rd_cyc[0] == wb_cyc[2] + 1, "R6 read after producer writeback",
          rd_cyc[0], wb_cyc[2] + 1);

    // R7: WAR hold of an early finisher
    issue(2, 1, 2, 3, a0);
    issue(0, 4, 1, 5, a1);
    issue(1, 5, 6, 6, a2);
    wait_cyc(25);
    check(wb_cyc[1] == rd_cyc[0] + 1, "R7 writeback held until reader read",
          wb_cyc[1], rd_cyc[0] + 1);
    check(wb_cyc[1] > rd_cyc[1] + lat[1] + 2, "R7 writeback later than unhindered",
          wb_cyc[1], rd_cyc[1] + lat[1] + 3);

    // R8: simultaneous completions, lowest index first
    auto_en = 4'b1100;
    issue(0, 10, 2, 3, a0);
    issue(1, 11, 2, 3, a1);
    wait_cyc(3);
    fire(4'b0011);
    wait_cyc(6);
    check(wb_cyc[1] == wb_cyc[0] + 1, "R8 priority order unit0 then unit1",
          wb_cyc[1], wb_cyc[0] + 1);
    auto_en = '1;
    wait_cyc(5);

    // R10: issue at the same edge as the producer's writeback
    auto_en = 4'b1011;
    issue(2, 9, 2, 3, a0);
    wait_cyc(3);
    fire(4'b0100);
    wait_cyc(1);
    issue(0, 12, 9, 9, a1);
    check(wb_cyc[2] == a1, "R10 ack coincides with producer writeback", wb_cyc[2], a1);
    wait_cyc(6);
    check(rd_cyc[0] == a1 + 1, "R10 source seen ready at issue", rd_cyc[0], a1 + 1);
    auto_en = '1;
    wait_cyc(10);

    // R9: done pulse to an idle unit is ignored
    n3 = wb_cnt[3];
    fire(4'b1000);
    wait_cyc(6);
    check(wb_cnt[3] == n3, "R9 spurious done gives no writeback", wb_cnt[3], n3);

    // mixed traffic on a few registers, checked cycle by cycle against the model
    for (int i = 0; i < 80; i++) begin
      issue(int'($urandom % NF), int'($urandom % 6), int'($urandom % 6),
            int'($urandom % 6), a0);
    end
    wait_cyc(40);
    finish_run();
  end
endmodule